// File: doc/BRIEF.md
# Write-Queue and Read-Buffer Channel Adapter

This block sits on the network side of a component wrapper and ties one network channel to the wrapper's internal bus. Writes from the internal bus enter a queue. Each entry holds an address and a data word. The queue empties toward the far side in fixed-size bursts over a request/acknowledge handshake. Read data coming back from the network lands in a single-word holding register. While that word waits to be collected, an interrupt line is asserted.

The adapter takes part in internal-bus traffic only while its enable input is high. This lets a module adapter or port adapter in front of several such blocks pick one at a time. When the queue is full, write acceptance stops and the full flag is raised. A flush input lets a short tail of fewer than a whole burst leave the queue.

Top module: `chan_adapter`

## Requirements
- R1: Queued words leave on `net_addr`/`net_data_out` in the order they were accepted, each with the address it was written with. The queue holds up to DEPTH (32) entries.
- R2: `full` is high and `ib_wready` is low exactly while DEPTH words are queued. A write offered while full is not queued.
- R3: While `ib_en` is low, write and read strobes from the internal bus have no effect. No word is queued and the read holding register is not cleared.
- R4: A burst begins only when at least BURST (4) words are queued, unless `wr_flush` is high. Without a flush, every burst carries exactly BURST words. No burst carries more than BURST words.
- R5: With `wr_flush` high and 1 to BURST-1 words queued, all queued words are sent in one burst.
- R6: `net_req` stays high until `net_ack` is seen. A word is transferred on each rising clock edge where both `net_req` and `net_ack` are high. While `net_req` is high and `net_ack` is low, `net_addr` and `net_data_out` hold their values.
- R7: `net_data_in` is captured on an edge where `net_rvalid` and `net_rready` are both high. `net_rready` is low while a captured word is unread, and the held word is not overwritten.
- R8: `irq` is high exactly while the holding register contains an unread word, which `ib_rdata` shows. An enabled read strobe (`ib_en` and `ib_rd` high) clears it on the next edge.
- R9: After reset, `net_req`, `irq` and `full` are low, and `ib_wready` and `net_rready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ib_en | input | 1 | Selects this adapter on the internal bus |
| ib_wr | input | 1 | Internal-bus write strobe |
| ib_addr | input | ADDR_W | Address stored with the written word |
| ib_wdata | input | DATA_W | Write data |
| ib_wready | output | 1 | Queue can accept a write |
| ib_rd | input | 1 | Internal-bus read strobe, collects the held word |
| ib_rdata | output | DATA_W | Held read word |
| irq | output | 1 | Unread word present in the holding register |
| wr_flush | input | 1 | Allow a burst shorter than BURST |
| full | output | 1 | Queue holds DEPTH words |
| net_req | output | 1 | Transfer request toward the network |
| net_ack | input | 1 | Network accepts the current word |
| net_addr | output | ADDR_W | Address of the word at the queue head |
| net_data_out | output | DATA_W | Data of the word at the queue head |
| net_data_in | input | DATA_W | Read data from the network |
| net_rvalid | input | 1 | `net_data_in` is valid |
| net_rready | output | 1 | Holding register is free |

## Verification
The bench builds the block with its default parameters: 16-bit address, 32-bit data, a 32-entry queue and bursts of 4. With ack held low, 32 writes are enough to reach the full boundary. A burst of 4 means every flush tail of 1 to 3 words, as well as whole bursts, comes up both in directed cases and under random acknowledge timing. Random enable, write and read traffic runs beside a random return-data stream, and a bench model of the queue and the holding register checks it.

// File: rtl/chan_pkg.sv
package chan_pkg;
  // burst engine states
  typedef enum logic {
    BS_IDLE = 1'b0,
    BS_RUN  = 1'b1
  } burst_state_e;
endpackage

// File: rtl/chan_wfifo.sv
module chan_wfifo #(
  parameter int DEPTH = 32,
  parameter int W     = 48,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign count   = cnt;
  assign rdata   = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    if (do_push) wr_ptr_n = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_n = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    cnt_n = cnt + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      cnt    <= cnt_n;
    end
  end

  // storage has no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> full && (count == $past(count)));
  a_r1_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/chan_burst.sv
module chan_burst
  import chan_pkg::*;
#(
  parameter int BURST = 4,
  parameter int CW    = 6,
  localparam int RW   = $clog2(BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          flush,
  input  logic          ack,
  output logic          req,
  output logic          pop
);
  burst_state_e st, st_n;
  logic [RW-1:0] rem, rem_n;

  always_comb begin
    st_n  = st;
    rem_n = rem;
    pop   = 1'b0;
    unique case (st)
      BS_IDLE: begin
        if (count >= CW'(BURST)) begin
          st_n  = BS_RUN;
          rem_n = RW'(BURST);
        end else if (flush && count != '0) begin
          st_n  = BS_RUN;
          rem_n = RW'(count);
        end
      end
      BS_RUN: begin
        if (ack) begin
          pop   = 1'b1;
          rem_n = rem - RW'(1);
          if (rem == RW'(1)) st_n = BS_IDLE;
        end
      end
      default: st_n = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BS_IDLE;
      rem <= '0;
    end else begin
      st  <= st_n;
      rem <= rem_n;
    end
  end

  assign req = (st == BS_RUN);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req);
  a_r4_start_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(count) >= CW'(BURST)) || $past(flush));
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= RW'(BURST));
endmodule

// File: rtl/chan_rdbuf.sv
module chan_rdbuf #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         irq
);
  logic         held, held_n;
  logic [W-1:0] word;
  logic         load, clear;

  assign in_ready = !held;
  assign load     = in_valid && !held;
  assign clear    = rd && held;

  always_comb begin
    held_n = held;
    if (load)       held_n = 1'b1;
    else if (clear) held_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= held_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (load) word <= in_data;
  end

  assign rdata = word;
  assign irq   = held;

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd && irq |=> !irq);
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !rd |=> irq && $stable(rdata));
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> irq && (rdata == $past(in_data)));
endmodule

// File: rtl/chan_adapter.sv
module chan_adapter #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ib_en,
  input  logic              ib_wr,
  input  logic [ADDR_W-1:0] ib_addr,
  input  logic [DATA_W-1:0] ib_wdata,
  output logic              ib_wready,
  input  logic              ib_rd,
  output logic [DATA_W-1:0] ib_rdata,
  output logic              irq,
  input  logic              wr_flush,
  output logic              full,
  output logic              net_req,
  input  logic              net_ack,
  output logic [ADDR_W-1:0] net_addr,
  output logic [DATA_W-1:0] net_data_out,
  input  logic [DATA_W-1:0] net_data_in,
  input  logic              net_rvalid,
  output logic              net_rready
);
  localparam int EW = ADDR_W + DATA_W;
  localparam int CW = $clog2(DEPTH) + 1;

  logic          wr_go, rd_go, pop, q_empty;
  logic [EW-1:0] head;
  logic [CW-1:0] q_count;

  assign wr_go = ib_en && ib_wr;
  assign rd_go = ib_en && ib_rd;

  chan_wfifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_go),
    .wdata ({ib_addr, ib_wdata}),
    .pop   (pop),
    .rdata (head),
    .count (q_count),
    .full  (full),
    .empty (q_empty)
  );

  chan_burst #(.BURST(BURST), .CW(CW)) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .count (q_count),
    .flush (wr_flush),
    .ack   (net_ack),
    .req   (net_req),
    .pop   (pop)
  );

  chan_rdbuf #(.W(DATA_W)) u_rdbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (net_rvalid),
    .in_data  (net_data_in),
    .in_ready (net_rready),
    .rd       (rd_go),
    .rdata    (ib_rdata),
    .irq      (irq)
  );

  assign ib_wready    = !full;
  assign net_addr     = head[EW-1 -: ADDR_W];
  assign net_data_out = head[DATA_W-1:0];

  a_r6_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    net_req && !net_ack |=> $stable(net_addr) && $stable(net_data_out));
  a_r1_req_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    net_req |-> !q_empty);
  a_r3_disabled_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !ib_en && !pop |=> q_count == $past(q_count));
endmodule

// File: tb/chan_adapter_tb.sv
module chan_adapter_tb;
  localparam int CLK_P  = 10;
  localparam int AW     = 16;
  localparam int DW     = 32;
  localparam int DEPTH  = 32;
  localparam int BURST  = 4;

  logic          clk, rst_n;
  logic          ib_en, ib_wr, ib_rd, wr_flush, net_ack, net_rvalid;
  logic [AW-1:0] ib_addr;
  logic [DW-1:0] ib_wdata, net_data_in;
  logic          ib_wready, irq, full, net_req, net_rready;
  logic [DW-1:0] ib_rdata, net_data_out;
  logic [AW-1:0] net_addr;

  chan_adapter #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .BURST(BURST)) u_dut (
    .clk(clk), .rst_n(rst_n), .ib_en(ib_en), .ib_wr(ib_wr), .ib_addr(ib_addr),
    .ib_wdata(ib_wdata), .ib_wready(ib_wready), .ib_rd(ib_rd), .ib_rdata(ib_rdata),
    .irq(irq), .wr_flush(wr_flush), .full(full), .net_req(net_req),
    .net_ack(net_ack), .net_addr(net_addr), .net_data_out(net_data_out),
    .net_data_in(net_data_in), .net_rvalid(net_rvalid), .net_rready(net_rready)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int sent   = 0;
  int ack_mode = 0;       // 0 hold low, 1 always high, 2 random
  bit flush_seen = 0;
  int burst_n = 0;
  bit prev_req = 0, prev_ack = 0;
  logic [AW+DW-1:0] prev_word;
  logic [AW+DW-1:0] expq [$];

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW+DW-1:0] pack_word(logic [AW-1:0] a, logic [DW-1:0] d);
    return {a, d};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // network-side model: drives ack, checks order, burst size and hold
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        net_ack  = 1'b0;
        prev_req = 1'b0;
        prev_ack = 1'b0;
      end else begin
        if (prev_req && !prev_ack)
          chk(net_req && ({net_addr, net_data_out} == prev_word),
              "R6 request/word held without ack", {31'd0, net_req, net_addr, net_data_out}, {16'd1, prev_word});
        case (ack_mode)
          0:       net_ack = 1'b0;
          1:       net_ack = 1'b1;
          default: net_ack = 1'($urandom_range(0, 1));
        endcase
        if (wr_flush) flush_seen = 1'b1;
        if (net_req && !prev_req) burst_n = 0;
        if (!net_req && prev_req) begin
          chk(burst_n <= BURST, "R4 burst too long", burst_n, BURST);
          if (!flush_seen) chk(burst_n == BURST, "R4 burst length without flush", burst_n, BURST);
          flush_seen = wr_flush;
        end
        if (net_req && net_ack) begin
          if (expq.size() == 0) chk(1'b0, "R1 unexpected word", {net_addr, net_data_out}, 0);
          else begin
            logic [AW+DW-1:0] e;
            e = expq.pop_front();
            chk({net_addr, net_data_out} == e, "R1 word order", {net_addr, net_data_out}, e);
          end
          burst_n++;
          sent++;
        end
        prev_req  = net_req;
        prev_ack  = net_ack;
        prev_word = {net_addr, net_data_out};
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic wr_word(input bit en, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ib_en = en; ib_wr = 1'b1; ib_addr = a; ib_wdata = d;
    if (en && !full) expq.push_back(pack_word(a, d));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    ib_wr = 1'b0; ib_rd = 1'b0; ib_en = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic drain(input int limit);
    for (int i = 0; i < limit && expq.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] d1, d2, exp_data;
    bit exp_valid;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; ib_en = 0; ib_wr = 0; ib_rd = 0; wr_flush = 0;
    ib_addr = '0; ib_wdata = '0; net_rvalid = 0; net_data_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!net_req, "R9 req after reset", net_req, 0);
    chk(!irq, "R9 irq after reset", irq, 0);
    chk(!full && ib_wready, "R9 full/wready after reset", {full, ib_wready}, 2'b01);
    chk(net_rready, "R9 rready after reset", net_rready, 1);

    // R3: writes with enable low are ignored
    ack_mode = 1;
    for (int i = 0; i < 6; i++) wr_word(1'b0, AW'(16'h100 + i), DW'(32'hdead_0000 + i));
    for (int i = 0; i < 8; i++) begin
      idle(1);
      chk(!net_req, "R3 disabled writes not queued", net_req, 0);
    end
    wr_flush = 1'b1;
    idle(5);
    chk(!net_req && sent == 0, "R3 flush finds nothing queued", sent, 0);
    wr_flush = 1'b0;

    // R4 / R5: three words wait, flush sends them
    for (int i = 0; i < 3; i++) wr_word(1'b1, AW'(16'h200 + i), DW'(32'h1111_0000 + i));
    for (int i = 0; i < 10; i++) begin
      idle(1);
      chk(!net_req, "R4 no burst below threshold", net_req, 0);
    end
    @(negedge clk); wr_flush = 1'b1;
    @(negedge clk); wr_flush = 1'b0;
    idle(10);
    chk(sent == 3 && expq.size() == 0, "R5 flush tail sent", sent, 3);

    // R2: fill with ack held low
    ack_mode = 0;
    for (int i = 0; i < DEPTH; i++) wr_word(1'b1, AW'(16'h300 + i), DW'(32'h2222_0000 + i));
    idle(1);
    chk(full && !ib_wready, "R2 full at depth", {full, ib_wready}, 2'b10);
    wr_word(1'b1, 16'hbeef, 32'hbad0_bad0);   // not queued: full when offered
    idle(2);
    chk(full, "R2 still full after blocked write", full, 1);
    ack_mode = 2;
    drain(600);
    chk(expq.size() == 0 && !full, "R2 drains after full", expq.size(), 0);
    chk(sent == 3 + DEPTH, "R1 all queued words sent", sent, 3 + DEPTH);

    // R7 / R8 read buffer
    d1 = 32'hcafe_0001; d2 = 32'hcafe_0002;
    @(negedge clk); net_rvalid = 1'b1; net_data_in = d1;
    @(negedge clk); net_data_in = d2;          // rvalid stays high
    chk(irq && ib_rdata == d1, "R8 irq and data after capture", ib_rdata, d1);
    chk(!net_rready, "R7 not ready while held", net_rready, 0);
    @(negedge clk);
    chk(ib_rdata == d1, "R7 held word not overwritten", ib_rdata, d1);
    ib_en = 1'b0; ib_rd = 1'b1;
    @(negedge clk);
    chk(irq, "R3 disabled read does not clear", irq, 1);
    ib_en = 1'b1; ib_rd = 1'b1;
    @(negedge clk);
    ib_en = 1'b0; ib_rd = 1'b0;
    chk(!irq && net_rready, "R8 enabled read clears", {irq, net_rready}, 2'b01);
    @(negedge clk);
    net_rvalid = 1'b0;
    chk(irq && ib_rdata == d2, "R7 next word captured", ib_rdata, d2);
    ib_en = 1'b1; ib_rd = 1'b1;
    @(negedge clk);
    ib_en = 1'b0; ib_rd = 1'b0;
    chk(!irq, "R8 cleared again", irq, 0);

    // random traffic
    exp_valid = 1'b0; exp_data = '0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      chk(irq == exp_valid, "R8 irq tracks held word", irq, exp_valid);
      if (exp_valid) chk(ib_rdata == exp_data, "R7 held data", ib_rdata, exp_data);
      ib_en  = ($urandom_range(0, 7) != 0);
      ib_wr  = ($urandom_range(0, 2) == 0);
      ib_addr = AW'($urandom);
      ib_wdata = $urandom;
      ib_rd  = exp_valid && ($urandom_range(0, 3) == 0);
      net_rvalid = 1'b0;
      if (ib_en && ib_wr && !full) expq.push_back(pack_word(ib_addr, ib_wdata));
      if (ib_en && ib_rd) exp_valid = 1'b0;
      else if (!exp_valid && $urandom_range(0, 4) == 0) begin
        net_rvalid = 1'b1;
        net_data_in = $urandom;
        exp_valid = 1'b1;
        exp_data = net_data_in;
      end
    end
    @(negedge clk);
    ib_wr = 0; ib_rd = 0; ib_en = 0; net_rvalid = 0;
    wr_flush = 1'b1;
    drain(800);
    wr_flush = 1'b0;
    idle(4);
    chk(expq.size() == 0, "R5 random tail flushed", expq.size(), 0);
    chk(!net_req, "R6 idle after drain", net_req, 0);

    summary();
    $finish;
  end
endmodule